// File: doc/BRIEF.md
# Fetch Target Predictor with Return-Address Stack

This block sits beside the fetch stage and proposes where fetch should go next. In the same cycle it looks up the fetch address in a direct-mapped, tagged target table. On a hit it predicts a jump to the stored target. It can also hand back the instruction word found at that target, so fetch of that word can be skipped. Procedure returns do not use the table, because a return lands at a different place for each caller. Their target comes from a small last-in-first-out stack: a call pushes the address after itself and a return pops it. The call and return indications arrive as inputs together with the fetch address.

A resolve port from a later pipeline stage reports the real outcome of each branch, together with what was predicted for it. A taken branch that is not a return is written into the table, replacing whatever held its slot. When the outcome differs from the prediction, the block raises a squash so that the speculative results are discarded before write-back. In that cycle it also gives fetch a redirect to the correct address.

Top module: `fetch_target_predictor`

## Requirements
- R1: After reset every table entry is invalid, so any non-return fetch gives `pred_taken`=0 and `pred_next_pc`=fetch_pc+4 until an entry has been written.
- R2: A resolve with `res_taken`=1 and `res_is_ret`=0 writes the target into the table slot for `res_pc`. From the next cycle on, a non-return fetch at that address gives `pred_taken`=1 and `pred_next_pc` equal to that target.
- R3: The slot index is fetch_pc[9:2] and the tag is fetch_pc[31:10]. A fetch that reaches an occupied slot with a different tag misses. A new allocation replaces the older entry in its slot.
- R4: On a table hit, `pred_insn_valid` and `pred_insn` return the instruction word and its valid flag that were stored with the entry.
- R5: A fetch with `fetch_is_call`=1 pushes fetch_pc+4. A fetch with `fetch_is_ret`=1 and a non-empty stack predicts taken to the most recently pushed address and pops it, so nested calls unwind in reverse order.
- R6: The stack holds 8 addresses. A push to a full stack overwrites the oldest entry, so after 9 pushes the 8 newest come back in reverse order and the 9th pop finds the stack empty.
- R7: A return fetched with an empty stack gives `pred_taken`=0, `pred_insn_valid`=0 and `pred_next_pc`=fetch_pc+4.
- R8: `redirect_valid` and `squash` rise in the cycle of a resolve whose taken flag differs from the predicted one, or that is taken to a target other than the predicted one. `redirect_pc` is then `res_target` if taken, else res_pc+4. Otherwise both stay low.
- R9: A return never takes its prediction from the table, even when its address hits there, and a return never delivers an instruction word.
- R10: When `fetch_is_call` and `fetch_is_ret` are both set, the fetch is treated as a return only and nothing is pushed.
- R11: A resolve with `res_taken`=0, or with `res_is_ret`=1, leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | 32 | Fetch address |
| fetch_is_call | input | 1 | The fetched instruction is a call |
| fetch_is_ret | input | 1 | The fetched instruction is a return |
| pred_taken | output | 1 | A target is predicted |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_insn_valid | output | 1 | `pred_insn` holds the target instruction |
| pred_insn | output | 32 | Stored instruction at the predicted target |
| res_valid | input | 1 | A branch outcome is reported |
| res_pc | input | 32 | Address of the resolved branch |
| res_is_ret | input | 1 | The resolved branch is a return |
| res_taken | input | 1 | The branch was taken |
| res_target | input | 32 | Computed target |
| res_insn | input | 32 | Instruction word at the target |
| res_insn_valid | input | 1 | `res_insn` may be stored |
| res_pred_taken | input | 1 | Taken flag that was predicted for it |
| res_pred_target | input | 32 | Target that was predicted for it |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Corrected fetch address |
| squash | output | 1 | Discard the speculative work after the branch |

## Verification
The bench targets aliasing addresses that share a slot but differ in tag. A design that compares too few tag bits would predict a stranger's target there, and one that did not replace on allocation would keep the stale entry. It drives nine nested calls and then unwinds them. A stack that saturates instead of wrapping, or that reports data when it is empty, returns the wrong address or a false hit. It also fetches returns at addresses that hit in the table and fetches call-and-return in one cycle, which catch designs that give the table priority or push on a return. The resolve checks cover the case of a correct direction with a wrong target, and a not-taken outcome whose redirect must point to the sequential address.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ   = 2'd0,
    SRC_TABLE = 2'd1,
    SRC_STACK = 2'd2
  } pred_src_e;
endpackage

// File: rtl/ftp_target_table.sv
module ftp_target_table #(
  parameter int ADDR_W  = 32,
  parameter int INSN_W  = 32,
  parameter int ENTRIES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_target,
  output logic [INSN_W-1:0] rd_insn,
  output logic              rd_insn_v,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [INSN_W-1:0] wr_insn,
  input  logic              wr_insn_v
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
    return pc[ADDR_W-1:IDX_W+2];
  endfunction

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q  [ENTRIES];
  logic [INSN_W-1:0]  insn_q [ENTRIES];
  logic [ENTRIES-1:0] insv_q;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             unused_low;

  assign rd_idx     = slot_of(rd_pc);
  assign wr_idx     = slot_of(wr_pc);
  assign unused_low = ^{rd_pc[1:0], wr_pc[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= tag_of(wr_pc);
      tgt_q[wr_idx]  <= wr_target;
      insn_q[wr_idx] <= wr_insn;
      insv_q[wr_idx] <= wr_insn_v;
    end
  end

  always_comb begin
    rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == tag_of(rd_pc));
    rd_target = tgt_q[rd_idx];
    rd_insn   = insn_q[rd_idx];
    rd_insn_v = rd_hit && insv_q[rd_idx];
  end

  // R2: an allocation leaves its slot valid in the next cycle
  assert_alloc_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/ftp_ret_stack.sv
module ftp_ret_stack #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  output logic              top_valid,
  output logic [ADDR_W-1:0] top_addr
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] ring_step(input logic [PW-1:0] p, input logic up);
    logic [PW:0] w;
    w = up ? ({1'b0, p} + 1'b1) : ({1'b0, p} + (PW+1)'(DEPTH - 1));
    return PW'(w % DEPTH);
  endfunction

  logic [ADDR_W-1:0] ent_q [DEPTH];
  logic [PW-1:0]     top_q;
  logic [CW-1:0]     cnt_q;
  logic              do_pop;

  assign do_pop    = pop && (cnt_q != '0);
  assign top_valid = (cnt_q != '0);
  assign top_addr  = ent_q[top_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
    end else if (do_pop) begin
      top_q <= ring_step(top_q, 1'b0);
      cnt_q <= cnt_q - 1'b1;
    end else if (push) begin
      top_q <= ring_step(top_q, 1'b1);
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !pop) ent_q[ring_step(top_q, 1'b1)] <= push_addr;
  end

  // R6: occupancy saturates at the depth instead of growing past it
  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R5: a push always leaves something to pop
  assert_push_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> top_valid);
endmodule

// File: rtl/ftp_resolve.sv
module ftp_resolve #(
  parameter int ADDR_W = 32
) (
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              res_pred_taken,
  input  logic [ADDR_W-1:0] res_pred_target,
  output logic              wrong,
  output logic [ADDR_W-1:0] fix_pc
);
  function automatic logic [ADDR_W-1:0] after(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(4);
  endfunction

  logic dir_bad, tgt_bad;
  assign dir_bad = res_taken != res_pred_taken;
  assign tgt_bad = res_taken && (res_target != res_pred_target);
  assign wrong   = res_valid && (dir_bad || tgt_bad);
  assign fix_pc  = res_taken ? res_target : after(res_pc);
endmodule

// File: rtl/fetch_target_predictor.sv
module fetch_target_predictor #(
  parameter int ADDR_W    = 32,
  parameter int INSN_W    = 32,
  parameter int ENTRIES   = 256,
  parameter int RAS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              fetch_is_call,
  input  logic              fetch_is_ret,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  output logic              pred_insn_valid,
  output logic [INSN_W-1:0] pred_insn,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_is_ret,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic [INSN_W-1:0] res_insn,
  input  logic              res_insn_valid,
  input  logic              res_pred_taken,
  input  logic [ADDR_W-1:0] res_pred_target,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              squash
);
  import ftp_pkg::*;

  function automatic logic [ADDR_W-1:0] seq_pc(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(4);
  endfunction

  logic              ret_fetch, call_fetch, tbl_write;
  logic              tbl_hit, tbl_insn_v, stk_valid, mis;
  logic [ADDR_W-1:0] tbl_target, stk_addr, fix_pc;
  logic [INSN_W-1:0] tbl_insn;
  pred_src_e         src;

  assign ret_fetch  = fetch_valid && fetch_is_ret;
  assign call_fetch = fetch_valid && fetch_is_call && !fetch_is_ret;
  assign tbl_write  = res_valid && res_taken && !res_is_ret;

  ftp_target_table #(.ADDR_W(ADDR_W), .INSN_W(INSN_W), .ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(fetch_pc), .rd_hit(tbl_hit), .rd_target(tbl_target),
    .rd_insn(tbl_insn), .rd_insn_v(tbl_insn_v),
    .wr_en(tbl_write), .wr_pc(res_pc), .wr_target(res_target),
    .wr_insn(res_insn), .wr_insn_v(res_insn_valid)
  );

  ftp_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(call_fetch), .pop(ret_fetch), .push_addr(seq_pc(fetch_pc)),
    .top_valid(stk_valid), .top_addr(stk_addr)
  );

  ftp_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .res_valid(res_valid), .res_taken(res_taken), .res_pc(res_pc),
    .res_target(res_target), .res_pred_taken(res_pred_taken),
    .res_pred_target(res_pred_target), .wrong(mis), .fix_pc(fix_pc)
  );

  always_comb begin
    if (ret_fetch)                  src = stk_valid ? SRC_STACK : SRC_SEQ;
    else if (fetch_valid && tbl_hit) src = SRC_TABLE;
    else                            src = SRC_SEQ;
  end

  always_comb begin
    pred_taken      = 1'b0;
    pred_next_pc    = seq_pc(fetch_pc);
    pred_insn_valid = 1'b0;
    pred_insn       = tbl_insn;
    case (src)
      SRC_TABLE: begin
        pred_taken      = 1'b1;
        pred_next_pc    = tbl_target;
        pred_insn_valid = tbl_insn_v;
      end
      SRC_STACK: begin
        pred_taken   = 1'b1;
        pred_next_pc = stk_addr;
      end
      default: ;
    endcase
  end

  assign redirect_valid = mis;
  assign redirect_pc    = fix_pc;
  assign squash         = mis;

  // R7: a return that finds the stack empty falls through sequentially
  assert_empty_pop_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fetch && !stk_valid) |-> (!pred_taken && pred_next_pc == fetch_pc + ADDR_W'(4)));
  // R9: a return never carries a table instruction word
  assert_ret_no_insn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fetch |-> !pred_insn_valid);
  // R8: an agreeing not-taken resolve never redirects
  assert_quiet_resolve_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && !res_pred_taken) |-> !redirect_valid);
  // R10: a combined call/return fetch does not grow the stack
  assert_ret_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_is_call && fetch_is_ret && !stk_valid) |=> !stk_valid);
endmodule

// File: tb/test_fetch_target_predictor.sv
`timescale 1ns/1ps
module test_fetch_target_predictor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid, fetch_is_call, fetch_is_ret;
  logic [31:0] fetch_pc;
  logic        pred_taken, pred_insn_valid;
  logic [31:0] pred_next_pc, pred_insn;
  logic        res_valid, res_is_ret, res_taken, res_insn_valid, res_pred_taken;
  logic [31:0] res_pc, res_target, res_insn, res_pred_target;
  logic        redirect_valid, squash;
  logic [31:0] redirect_pc;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] m_tgt  [int];
  logic [31:0] m_tag  [int];
  logic [31:0] m_insn [int];
  logic        m_insv [int];
  logic [31:0] m_stk  [$];

  always #2.5 clk = ~clk;

  fetch_target_predictor i_fetch_target_predictor (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_is_call(fetch_is_call), .fetch_is_ret(fetch_is_ret),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .pred_insn_valid(pred_insn_valid), .pred_insn(pred_insn),
    .res_valid(res_valid), .res_pc(res_pc), .res_is_ret(res_is_ret),
    .res_taken(res_taken), .res_target(res_target), .res_insn(res_insn),
    .res_insn_valid(res_insn_valid), .res_pred_taken(res_pred_taken),
    .res_pred_target(res_pred_target), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .squash(squash)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req,
                      input logic fv, input logic [31:0] pc, input logic call, input logic ret,
                      input logic rv, input logic [31:0] rpc, input logic rret, input logic rt,
                      input logic [31:0] rtgt, input logic [31:0] rins, input logic rinsv,
                      input logic rpt, input logic [31:0] rptgt);
    int idx;
    logic e_tk, e_iv, mis;
    logic [31:0] e_nx, e_in;
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc; fetch_is_call = call; fetch_is_ret = ret;
    res_valid = rv; res_pc = rpc; res_is_ret = rret; res_taken = rt; res_target = rtgt;
    res_insn = rins; res_insn_valid = rinsv; res_pred_taken = rpt; res_pred_target = rptgt;
    #1;
    idx = int'((pc / 4) % 256);
    e_tk = 1'b0; e_nx = pc + 4; e_iv = 1'b0; e_in = 32'h0;
    if (fv && ret) begin
      if (m_stk.size() > 0) begin e_tk = 1'b1; e_nx = m_stk[m_stk.size()-1]; end
    end else if (fv && m_tgt.exists(idx) && m_tag[idx] == (pc >> 10)) begin
      e_tk = 1'b1; e_nx = m_tgt[idx]; e_iv = m_insv[idx]; e_in = m_insn[idx];
    end
    chk(req, "pred_taken", {31'b0, pred_taken}, {31'b0, e_tk});
    chk(req, "pred_next_pc", pred_next_pc, e_nx);
    chk(req, "pred_insn_valid", {31'b0, pred_insn_valid}, {31'b0, e_iv});
    if (e_iv) chk(req, "pred_insn", pred_insn, e_in);
    mis = rv && ((rt != rpt) || (rt && rtgt != rptgt));
    chk(req, "redirect_valid", {31'b0, redirect_valid}, {31'b0, mis});
    chk(req, "squash", {31'b0, squash}, {31'b0, mis});
    if (mis) chk(req, "redirect_pc", redirect_pc, rt ? rtgt : rpc + 4);
    if (fv && ret) begin
      if (m_stk.size() > 0) void'(m_stk.pop_back());
    end else if (fv && call) begin
      m_stk.push_back(pc + 4);
      if (m_stk.size() > 8) void'(m_stk.pop_front());
    end
    if (rv && rt && !rret) begin
      idx = int'((rpc / 4) % 256);
      m_tgt[idx] = rtgt; m_tag[idx] = rpc >> 10; m_insn[idx] = rins; m_insv[idx] = rinsv;
    end
  endtask

  task automatic fetch(input string req, input logic [31:0] pc, input logic call, input logic ret);
    step(req, 1'b1, pc, call, ret, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic resolve(input string req, input logic [31:0] rpc, input logic rret, input logic rt,
                         input logic [31:0] rtgt, input logic [31:0] rins, input logic rinsv,
                         input logic rpt, input logic [31:0] rptgt);
    step(req, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, rpc, rret, rt, rtgt, rins, rinsv, rpt, rptgt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_valid = 0; fetch_pc = 0; fetch_is_call = 0; fetch_is_ret = 0;
    res_valid = 0; res_pc = 0; res_is_ret = 0; res_taken = 0; res_target = 0;
    res_insn = 0; res_insn_valid = 0; res_pred_taken = 0; res_pred_target = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty table after reset
    fetch("R1", 32'h0000_1000, 1'b0, 1'b0);
    fetch("R1", 32'h0000_1400, 1'b0, 1'b0);
    fetch("R1", 32'hFFFF_FFFC, 1'b0, 1'b0);

    // R8 + R2 + R4: allocate via a mispredicted taken branch, then hit with instruction
    resolve("R8", 32'h0000_1000, 1'b0, 1'b1, 32'h0000_2000, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'h0);
    fetch("R2", 32'h0000_1000, 1'b0, 1'b0);
    fetch("R4", 32'h0000_1000, 1'b0, 1'b0);

    // R3: same slot, different tag misses; reallocation replaces
    fetch("R3", 32'h0000_1400, 1'b0, 1'b0);
    resolve("R3", 32'h0000_1400, 1'b0, 1'b1, 32'h0000_5000, 32'h0, 1'b0, 1'b0, 32'h0);
    fetch("R3", 32'h0000_1000, 1'b0, 1'b0);
    fetch("R3", 32'h0000_1400, 1'b0, 1'b0);

    // R8: correct prediction, wrong target with right direction, not-taken mispredict
    resolve("R8", 32'h0000_1400, 1'b0, 1'b1, 32'h0000_5000, 32'h0, 1'b0, 1'b1, 32'h0000_5000);
    resolve("R8", 32'h0000_1400, 1'b0, 1'b1, 32'h0000_6000, 32'h0, 1'b0, 1'b1, 32'h0000_5000);
    resolve("R11", 32'h0000_1400, 1'b0, 1'b0, 32'h0000_7000, 32'h0, 1'b0, 1'b1, 32'h0000_6000);
    fetch("R11", 32'h0000_1400, 1'b0, 1'b0);
    resolve("R11", 32'h0000_3000, 1'b1, 1'b1, 32'h0000_9000, 32'h0, 1'b0, 1'b1, 32'h0000_9000);
    fetch("R11", 32'h0000_3000, 1'b0, 1'b0);

    // R5: nested calls unwind in reverse; R7: empty stack
    fetch("R5", 32'h0000_0100, 1'b1, 1'b0);
    fetch("R5", 32'h0000_0200, 1'b1, 1'b0);
    fetch("R5", 32'h0000_0300, 1'b0, 1'b1);
    fetch("R5", 32'h0000_0304, 1'b0, 1'b1);
    fetch("R7", 32'h0000_0308, 1'b0, 1'b1);

    // R6: nine pushes, nine pops
    for (int k = 0; k < 9; k++) fetch("R6", 32'h0000_4000 + 32'(k * 16), 1'b1, 1'b0);
    for (int k = 0; k < 9; k++) fetch("R6", 32'h0000_8000 + 32'(k * 4), 1'b0, 1'b1);

    // R9: return at a table-hitting address
    fetch("R9", 32'h0000_1400, 1'b0, 1'b1);
    fetch("R9", 32'h0000_0ff0, 1'b1, 1'b0);
    fetch("R9", 32'h0000_1400, 1'b0, 1'b1);

    // R10: call and return together only pop
    fetch("R10", 32'h0000_0a00, 1'b1, 1'b0);
    fetch("R10", 32'h0000_0b00, 1'b1, 1'b1);
    fetch("R10", 32'h0000_0c00, 1'b0, 1'b1);

    // mixed traffic against the reference model
    for (int n = 0; n < 600; n++) begin
      logic [31:0] pc, rpc, t;
      pc  = {20'h0, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 7)), 2'b00};
      rpc = {20'h0, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 7)), 2'b00};
      t   = {16'h0, 14'($urandom), 2'b00};
      step("R2", 1'($urandom), pc, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom), rpc, 1'($urandom_range(0, 7) == 0), 1'($urandom), t, $urandom,
           1'($urandom), 1'($urandom), ($urandom_range(0, 1) == 1) ? t : t + 4);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule